// File: doc/BRIEF.md
# Lockable Save-Area Window Register

This block holds one 8-bit feature register that sets up, and then seals, a protected window over a fixed range of addresses used as a save area. Software first writes a query code. The register answers with a capability code, and after that only the lock bit can still be written. Once the lock bit is set, the register freezes for good.

After the lock, the block also acts as an address filter for that range. A normal-mode access is sunk: reads return all ones and writes never reach memory. A protected-mode access is steered to the save-area memory. Before the lock, the range behaves like ordinary memory for every access.

A build parameter can remove the feature entirely. In that case the register reads zero and no write can change the window.

Top module: `slw_window`

## Requirements
- R1: After reset the register reads 0x00 and the window is not locked.
- R2: Writing the query code 0xFF while the register has not yet been queried makes it read the capability code 0x01 from the next cycle on.
- R3: Before any query, a written value other than 0xFF is discarded and the register reads 0x00. This includes 0x02, which does not lock.
- R4: After a query, a write with bit 1 (value 0x02) set locks the window, and the register then reads 0x02.
- R5: After a query, a write with bit 1 clear leaves the register at 0x01, whatever the other bits hold.
- R6: Once locked, the register keeps reading 0x02 and stays locked under any further write.
- R7: While locked, a normal-mode access inside the range returns 0xFFFFFFFF on the access data and does not raise the memory write enable.
- R8: While locked, a protected-mode access inside the range selects the save-area memory, passes the memory read data through, and passes writes.
- R9: While unlocked, every access inside the range passes straight to memory, with neither the sink nor the protected select asserted.
- R10: Accesses outside the range are never sunk or selected, whatever the lock state.
- R11: With the feature parameter off, the register always reads 0x00 and writes never lock or sink anything.
- R12: The range covers base (default 0x30000) up to base plus size minus one (default 0x3FFFF). The addresses just below the base and at base plus size lie outside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Byte write strobe for the feature register |
| cfg_wdata | input | 8 | Write data for the feature register |
| cfg_rdata | output | 8 | Current register value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_prot | input | 1 | The access is made in protected mode |
| acc_write | input | 1 | The access is a write |
| acc_addr | input | AW | Access address |
| mem_rdata | input | DW | Read data returned by memory |
| acc_rdata | output | DW | Read data returned to the requester |
| mem_write | output | 1 | Write enable forwarded to memory |
| win_sink | output | 1 | The access is being sunk |
| win_prot_sel | output | 1 | The access is steered to the save-area memory |
| win_locked | output | 1 | The window is locked |

## Verification
The assertions assume that reset is applied before the first write and that the write strobe comes from a synchronous source. They also rely on the register reading 0x00 only in the unqueried phase. The assertions for the three-phase sequence hold only when the feature is present; with the feature off, the checker holds the outputs at zero instead. The stimulus drives both instances, one with the feature and one without, from the same inputs. Every input changes one time unit after a falling edge, and each value is held for a full cycle. The values walk through every phase, then probe both edges of the address range in each mode.

// File: rtl/slw_pkg.sv
package slw_pkg;
   typedef enum logic [1:0] {
      PH_OPEN   = 2'd0,
      PH_NEGOT  = 2'd1,
      PH_LOCKED = 2'd2
   } phase_e;

   localparam int          LOCK_POS   = 1;
   localparam logic [7:0]  QUERY_CODE = 8'hFF;
   localparam logic [7:0]  CAP_CODE   = 8'h01;
   localparam logic [7:0]  LOCK_BIT   = 8'(1 << LOCK_POS);

   function automatic logic [7:0] phase_mask(input phase_e p);
      case (p)
         PH_OPEN:  phase_mask = 8'hFF;
         PH_NEGOT: phase_mask = LOCK_BIT;
         default:  phase_mask = 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/slw_handshake.sv
module slw_handshake
   import slw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output logic [7:0] value,
   output logic       locked
);
   phase_e     ph_q, ph_d;
   logic [7:0] val_q, val_d, mask, merged;

   always_comb begin
      mask   = phase_mask(ph_q);
      merged = (val_q & ~mask) | (wdata & mask);
      ph_d   = ph_q;
      val_d  = val_q;
      if (we) begin
         if (merged == QUERY_CODE) begin
            ph_d  = PH_NEGOT;
            val_d = CAP_CODE;
         end else begin
            val_d = (ph_q == PH_OPEN) ? 8'h00 : merged;
            if (val_d[LOCK_POS]) begin
               ph_d  = PH_LOCKED;
               val_d = LOCK_BIT;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_OPEN;
         val_q <= 8'h00;
      end else begin
         ph_q  <= ph_d;
         val_q <= val_d;
      end
   end

   assign value  = val_q;
   assign locked = (ph_q == PH_LOCKED);
endmodule

// File: rtl/slw_decode.sv
module slw_decode #(
   parameter int              AW       = 20,
   parameter int              DW       = 32,
   parameter longint unsigned WIN_BASE = 64'h30000,
   parameter longint unsigned WIN_SIZE = 64'h10000
) (
   input  logic          locked,
   input  logic          acc_valid,
   input  logic          acc_prot,
   input  logic          acc_write,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] acc_rdata,
   output logic          mem_write,
   output logic          sink,
   output logic          prot_sel
);
   localparam logic [AW:0] LO = (AW+1)'(WIN_BASE);
   localparam logic [AW:0] HI = (AW+1)'(WIN_BASE + WIN_SIZE);

   logic [AW:0] addr_x;
   logic        in_range;

   assign addr_x    = {1'b0, acc_addr};
   assign in_range  = (addr_x >= LO) && (addr_x < HI);
   assign sink      = locked && acc_valid && in_range && !acc_prot;
   assign prot_sel  = locked && acc_valid && in_range && acc_prot;
   assign acc_rdata = sink ? {DW{1'b1}} : mem_rdata;
   assign mem_write = acc_valid && acc_write && !sink;
endmodule

// File: rtl/slw_window.sv
module slw_window #(
   parameter int              AW       = 20,
   parameter int              DW       = 32,
   parameter longint unsigned WIN_BASE = 64'h30000,
   parameter longint unsigned WIN_SIZE = 64'h10000,
   parameter bit              ENABLE   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [7:0]    cfg_wdata,
   output logic [7:0]    cfg_rdata,
   input  logic          acc_valid,
   input  logic          acc_prot,
   input  logic          acc_write,
   input  logic [AW-1:0] acc_addr,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] acc_rdata,
   output logic          mem_write,
   output logic          win_sink,
   output logic          win_prot_sel,
   output logic          win_locked
);
   localparam longint unsigned SPACE = 64'd1 << AW;

   initial begin
      assert (WIN_SIZE > 0 && WIN_BASE + WIN_SIZE <= SPACE)
         else $error("window does not fit in the address space");
      assert (AW > 0 && AW < 63 && DW > 0)
         else $error("bad width parameters");
   end

   logic locked;

   generate
      if (ENABLE) begin : g_feature
         slw_handshake u_hs (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (cfg_we),
            .wdata  (cfg_wdata),
            .value  (cfg_rdata),
            .locked (locked)
         );
      end else begin : g_absent
         assign cfg_rdata = 8'h00;
         assign locked    = 1'b0;
      end
   endgenerate

   slw_decode #(
      .AW(AW), .DW(DW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
   ) u_dec (
      .locked    (locked),
      .acc_valid (acc_valid),
      .acc_prot  (acc_prot),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .mem_rdata (mem_rdata),
      .acc_rdata (acc_rdata),
      .mem_write (mem_write),
      .sink      (win_sink),
      .prot_sel  (win_prot_sel)
   );

   assign win_locked = locked;
endmodule

// File: rtl/slw_window_chk.sv
module slw_window_chk #(
   parameter int DW     = 32,
   parameter bit ENABLE = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic [7:0]    cfg_wdata,
   input logic [7:0]    cfg_rdata,
   input logic [DW-1:0] acc_rdata,
   input logic          mem_write,
   input logic          win_sink,
   input logic          win_prot_sel,
   input logic          win_locked
);
   a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      win_locked |=> win_locked);
   a_r4_lock_value: assert property (@(posedge clk) disable iff (!rst_n)
      win_locked |-> cfg_rdata == 8'h02);
   a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      win_sink |-> !mem_write);
   a_r7_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      win_sink |-> acc_rdata == {DW{1'b1}});
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_sink && win_prot_sel));
   a_r9_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !win_locked |-> !win_sink && !win_prot_sel);
   a_r2_query: assert property (@(posedge clk) disable iff (!rst_n)
      (ENABLE && cfg_we && cfg_wdata == 8'hFF && cfg_rdata == 8'h00) |=> cfg_rdata == 8'h01);
   a_r3_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (ENABLE && cfg_we && cfg_wdata != 8'hFF && cfg_rdata == 8'h00) |=> cfg_rdata == 8'h00);
   a_r11_absent: assert property (@(posedge clk) disable iff (!rst_n)
      !ENABLE |-> cfg_rdata == 8'h00 && !win_locked);
endmodule

bind slw_window slw_window_chk #(.DW(DW), .ENABLE(ENABLE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_wdata    (cfg_wdata),
   .cfg_rdata    (cfg_rdata),
   .acc_rdata    (acc_rdata),
   .mem_write    (mem_write),
   .win_sink     (win_sink),
   .win_prot_sel (win_prot_sel),
   .win_locked   (win_locked)
);

// File: tb/sim_slw_window.sv
`timescale 1ns/100ps
module sim_slw_window;
   localparam int AW = 20;
   localparam int DW = 32;

   typedef struct {
      int          sig;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_wdata = 8'h00;
   logic          acc_valid = 1'b0, acc_prot = 1'b0, acc_write = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [DW-1:0] mem_rdata = '0;
   logic [7:0]    rd0, rd1;
   logic [DW-1:0] ard0, ard1;
   logic          mw0, mw1, sk0, sk1, ps0, ps1, lk0, lk1;

   item_t q[$];
   int    n_run = 0;
   int    n_fail = 0;
   bit    finished = 1'b0;

   always #2.5 clk = ~clk;

   slw_window u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd0),
      .acc_valid(acc_valid), .acc_prot(acc_prot), .acc_write(acc_write), .acc_addr(acc_addr),
      .mem_rdata(mem_rdata), .acc_rdata(ard0), .mem_write(mw0), .win_sink(sk0),
      .win_prot_sel(ps0), .win_locked(lk0));

   slw_window #(.ENABLE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1),
      .acc_valid(acc_valid), .acc_prot(acc_prot), .acc_write(acc_write), .acc_addr(acc_addr),
      .mem_rdata(mem_rdata), .acc_rdata(ard1), .mem_write(mw1), .win_sink(sk1),
      .win_prot_sel(ps1), .win_locked(lk1));

   function automatic logic [31:0] sample(input int s);
      case (s)
         0: sample = {24'h0, rd0};
         1: sample = {31'h0, lk0};
         2: sample = ard0;
         3: sample = {31'h0, mw0};
         4: sample = {31'h0, sk0};
         5: sample = {31'h0, ps0};
         6: sample = {24'h0, rd1};
         7: sample = {31'h0, sk1};
         default: sample = {31'h0, lk1};
      endcase
   endfunction

   task automatic push(input int s, input logic [31:0] e, input string t);
      item_t it;
      it.sig = s; it.exp = e; it.tag = t;
      q.push_back(it);
   endtask

   // monitor: compares every pending expectation at the falling edge
   initial forever begin
      @(negedge clk);
      while (q.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it  = q.pop_front();
         got = sample(it.sig);
         n_run++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s sig%0d: actual %h expected %h", it.tag, it.sig, got, it.exp);
         end
      end
   end

   task automatic cfg_write(input logic [7:0] v, input logic [7:0] e, input logic el, input string t);
      @(negedge clk); #1;
      cfg_we = 1'b1; cfg_wdata = v;
      push(0, {24'h0, e}, t);
      push(1, {31'h0, el}, t);
      push(6, 32'h0, "R11 absent reg");
      push(8, 32'h0, "R11 absent lock");
      @(negedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic access(input logic [AW-1:0] a, input logic p, input logic w,
                         input logic [31:0] md, input logic [31:0] er,
                         input logic ew, input logic es, input logic ep, input string t);
      @(negedge clk); #1;
      acc_valid = 1'b1; acc_addr = a; acc_prot = p; acc_write = w; mem_rdata = md;
      push(2, er, t);
      push(3, {31'h0, ew}, t);
      push(4, {31'h0, es}, t);
      push(5, {31'h0, ep}, t);
      push(7, 32'h0, "R11 absent sink");
      @(negedge clk); #1;
      acc_valid = 1'b0;
   endtask

   initial begin
      push(0, 32'h0, "R1 reset reg");
      push(1, 32'h0, "R1 reset lock");
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;

      access(20'h30010, 1'b0, 1'b1, 32'h12345678, 32'h12345678, 1'b1, 1'b0, 1'b0, "R9 unlocked normal");
      cfg_write(8'h02, 8'h00, 1'b0, "R3 lock before query");
      cfg_write(8'h5A, 8'h00, 1'b0, "R3 other before query");
      cfg_write(8'hFF, 8'h01, 1'b0, "R2 query");
      cfg_write(8'h00, 8'h01, 1'b0, "R5 zero after query");
      cfg_write(8'hFD, 8'h01, 1'b0, "R5 bit1 clear");
      access(20'h30000, 1'b1, 1'b0, 32'h0BADF00D, 32'h0BADF00D, 1'b0, 1'b0, 1'b0, "R9 unlocked prot");
      cfg_write(8'h02, 8'h02, 1'b1, "R4 lock");
      cfg_write(8'h00, 8'h02, 1'b1, "R6 clear after lock");
      cfg_write(8'hFF, 8'h02, 1'b1, "R6 query after lock");
      access(20'h30000, 1'b0, 1'b1, 32'h0000A5A5, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, "R7 sink at base");
      access(20'h3FFFF, 1'b1, 1'b1, 32'hCAFE0001, 32'hCAFE0001, 1'b1, 1'b0, 1'b1, "R8 R12 prot at top");
      access(20'h3FFFF, 1'b0, 1'b0, 32'h11110000, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, "R12 R7 sink at top");
      access(20'h2FFFF, 1'b0, 1'b1, 32'h22223333, 32'h22223333, 1'b1, 1'b0, 1'b0, "R10 R12 below base");
      access(20'h40000, 1'b1, 1'b1, 32'h44445555, 32'h44445555, 1'b1, 1'b0, 1'b0, "R10 R12 past end");
      access(20'h80000, 1'b0, 1'b0, 32'h66667777, 32'h66667777, 1'b0, 1'b0, 1'b0, "R10 far away");

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule